// File: doc/BRIEF.md
# Receive Alarm Status and Interrupt Unit

This unit gathers six real-time receive alarm conditions and two counter-saturation indications into one eight-bit status byte. It raises a single active-high interrupt line, gated bit by bit by a host-written mask. It also keeps three saturating event counters: one 8-bit counter for line code violations and two 4-bit counters for framing and check errors. The host can preset any of these counters.

The two kinds of interrupt clear in different ways. A real-time flag latches on a rising condition. A plain status read clears it, but only if the condition has gone low by the time of that read. A saturation flag ignores reads of every kind and drops only when the host presets the counter to a value other than all ones. A read marked as part of a burst clears nothing.

Top module: `rxAlarmStatus`

## Requirements
- R1: The status byte holds, from bit 7 down to bit 0: violation-counter saturation, error-counter saturation, then real-time flags yellow alarm (alarmLevel[5]), carrier loss ([4]), frame-bit error ([3]), zero-substitution detect ([2]), blue alarm ([1]), loss of sync ([0]). Real-time flag n sits at status bit n.
- R2: A real-time flag is set at the first clock edge where its condition input is high and was low at the previous edge. It shows on statusByte after that edge. A condition that stays high or falls sets nothing.
- R3: A direct read (statusRd=1, burstRd=0) clears, at that edge, each real-time flag whose condition is low in the same cycle. A flag whose condition is still high stays set.
- R4: A burst read (statusRd=1, burstRd=1) leaves every status bit unchanged.
- R5: The violation counter adds one for each cycle with bvEvent high. It stops at 255 and does not wrap. Status bit 7 is 1 exactly while that counter holds 255.
- R6: Each 4-bit error counter (errEvent[0] feeds A, errEvent[1] feeds B) stops at 15. Status bit 6 is 1 while either counter holds 15.
- R7: Status bits 7 and 6 are unaffected by any read. They fall only after a host write gives the counter a value other than all ones. For bit 6, the other error counter must also be below 15.
- R8: A host write to a counter in the same cycle as that counter's event loads the written value, and the event is discarded.
- R9: irq is registered and equals the OR over the bits of (statusByte AND mask), updating on the same edge as statusByte. A mask write takes effect at its own edge.
- R10: After reset the status byte, mask, all counters and irq are zero.
- R11: Host write addresses: 0 loads the mask, 1 the violation counter, 2 error counter A, 3 error counter B. Error counters take wrData[3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| alarmLevel | input | 6 | Real-time alarm condition levels |
| bvEvent | input | 1 | Violation event strobe, one count per cycle high |
| errEvent | input | 2 | Error event strobes for counters A and B |
| statusRd | input | 1 | Host read of the status byte |
| burstRd | input | 1 | Marks the read as part of a burst |
| wrEn | input | 1 | Host write enable |
| wrAddr | input | 2 | Host write address |
| wrData | input | 8 | Host write data |
| statusByte | output | 8 | Latched status flags |
| bvCount | output | 8 | Violation counter value |
| errCountA | output | 4 | Error counter A value |
| errCountB | output | 4 | Error counter B value |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench reads a flag while its condition is still high and confirms the flag survives; a design that cleared on every read would lose it. It repeats reads as bursts, which a design ignoring the burst qualifier would turn into clears. It counts the violation counter past 255 and fires an event in the same cycle as a preset, catching wrap-around and event-wins-over-write errors. It also presets only one of two saturated error counters, so a design that cleared bit 6 per counter rather than on both would drop the flag too early.

// File: rtl/alarmPkg.sv
package alarmPkg;
  typedef struct packed {
    logic ldMask;
    logic ldBv;
    logic ldErrA;
    logic ldErrB;
    logic rdClear;
  } hostStrobes_t;

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_BV   = 2'd1;
  localparam logic [1:0] ADDR_ERRA = 2'd2;
  localparam logic [1:0] ADDR_ERRB = 2'd3;
endpackage

// File: rtl/satCounter.sv
module satCounter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         fullNext
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [W-1:0] countNext;

  always_comb begin
    countNext = count;
    if (load)                    countNext = loadVal;
    else if (inc && count != FULL) countNext = count + 1'b1;
  end

  assign fullNext = (countNext == FULL);

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= countNext;
  end

  // R5 R6: a full counter never wraps
  p_hold_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULL && !load) |=> (count == FULL));

  // R8: preset beats a coincident event
  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (count == $past(loadVal)));
endmodule

// File: rtl/alarmCtrl.sv
module alarmCtrl
  import alarmPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         statusRd,
  input  logic         burstRd,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  output hostStrobes_t strobes
);
  always_comb begin
    strobes.ldMask  = wrEn && (wrAddr == ADDR_MASK);
    strobes.ldBv    = wrEn && (wrAddr == ADDR_BV);
    strobes.ldErrA  = wrEn && (wrAddr == ADDR_ERRA);
    strobes.ldErrB  = wrEn && (wrAddr == ADDR_ERRB);
    strobes.rdClear = statusRd && !burstRd;
  end

  // R11: a write targets at most one register
  p_one_target_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.ldMask, strobes.ldBv, strobes.ldErrA, strobes.ldErrB}));
endmodule

// File: rtl/alarmDatapath.sv
module alarmDatapath
  import alarmPkg::*;
#(
  parameter int RT_N  = 6,
  parameter int BV_W  = 8,
  parameter int ERR_W = 4,
  parameter int WR_W  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  hostStrobes_t          strobes,
  input  logic [WR_W-1:0]       wrData,
  input  logic [RT_N-1:0]       alarmLevel,
  input  logic                  bvEvent,
  input  logic [1:0]            errEvent,
  output logic [RT_N+1:0]       statusByte,
  output logic [BV_W-1:0]       bvCount,
  output logic [ERR_W-1:0]      errCountA,
  output logic [ERR_W-1:0]      errCountB,
  output logic                  irq
);
  localparam int ST_W = RT_N + 2;

  logic [ST_W-1:0]  mask, maskNext, statusNext;
  logic [RT_N-1:0]  condPrev, rtFlags, rtNext, rising;
  logic             bvFullNext, bvSatQ, errSatQ;
  logic [1:0]       errFullNext, errLoad;
  logic [ERR_W-1:0] errCount [2];

  assign rising = alarmLevel & ~condPrev;

  genvar i;
  generate
    for (i = 0; i < RT_N; i++) begin : g_rt
      always_comb begin
        rtNext[i] = rtFlags[i];
        if (strobes.rdClear && !alarmLevel[i]) rtNext[i] = 1'b0;
        if (rising[i])                         rtNext[i] = 1'b1;
      end
    end
  endgenerate

  satCounter #(.W(BV_W)) uBv (
    .clk(clk), .rstN(rstN), .load(strobes.ldBv), .loadVal(wrData[BV_W-1:0]),
    .inc(bvEvent), .count(bvCount), .fullNext(bvFullNext)
  );

  assign errLoad = {strobes.ldErrB, strobes.ldErrA};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_err
      satCounter #(.W(ERR_W)) uErr (
        .clk(clk), .rstN(rstN), .load(errLoad[g]), .loadVal(wrData[ERR_W-1:0]),
        .inc(errEvent[g]), .count(errCount[g]), .fullNext(errFullNext[g])
      );
    end
  endgenerate

  assign errCountA = errCount[0];
  assign errCountB = errCount[1];

  assign maskNext   = strobes.ldMask ? wrData[ST_W-1:0] : mask;
  assign statusNext = {bvFullNext, |errFullNext, rtNext};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask     <= '0;
      condPrev <= '0;
      rtFlags  <= '0;
      bvSatQ   <= 1'b0;
      errSatQ  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      mask     <= maskNext;
      condPrev <= alarmLevel;
      rtFlags  <= rtNext;
      bvSatQ   <= bvFullNext;
      errSatQ  <= |errFullNext;
      irq      <= |(statusNext & maskNext);
    end
  end

  assign statusByte = {bvSatQ, errSatQ, rtFlags};

  // R2: a rising condition leaves its flag set
  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rising != '0) |=> ((rtFlags & $past(rising)) == $past(rising)));

  // R3: a read never clears a flag whose condition is live
  p_live_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdClear |=>
      ((rtFlags & $past(rtFlags & alarmLevel)) == $past(rtFlags & alarmLevel)));

  // R4: without a clearing read no real-time flag drops
  p_no_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdClear |=> ((rtFlags & $past(rtFlags)) == $past(rtFlags)));

  // R7: saturation flag survives unless the counter is preset
  p_sat_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[ST_W-1] && !strobes.ldBv) |=> statusByte[ST_W-1]);

  // R9: interrupt only from an enabled flag
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((statusByte & mask) != '0));
endmodule

// File: rtl/rxAlarmStatus.sv
module rxAlarmStatus
  import alarmPkg::*;
#(
  parameter int RT_N  = 6,
  parameter int BV_W  = 8,
  parameter int ERR_W = 4,
  parameter int WR_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RT_N-1:0]  alarmLevel,
  input  logic             bvEvent,
  input  logic [1:0]       errEvent,
  input  logic             statusRd,
  input  logic             burstRd,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [WR_W-1:0]  wrData,
  output logic [RT_N+1:0]  statusByte,
  output logic [BV_W-1:0]  bvCount,
  output logic [ERR_W-1:0] errCountA,
  output logic [ERR_W-1:0] errCountB,
  output logic             irq
);
  hostStrobes_t strobes;

  alarmCtrl uCtrl (
    .clk(clk), .rstN(rstN), .statusRd(statusRd), .burstRd(burstRd),
    .wrEn(wrEn), .wrAddr(wrAddr), .strobes(strobes)
  );

  alarmDatapath #(.RT_N(RT_N), .BV_W(BV_W), .ERR_W(ERR_W), .WR_W(WR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .alarmLevel(alarmLevel), .bvEvent(bvEvent), .errEvent(errEvent),
    .statusByte(statusByte), .bvCount(bvCount), .errCountA(errCountA),
    .errCountB(errCountB), .irq(irq)
  );
endmodule

// File: tb/rxAlarmStatus_test.sv
module rxAlarmStatus_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] alarmLevel = '0;
  logic       bvEvent = 1'b0;
  logic [1:0] errEvent = '0;
  logic       statusRd = 1'b0;
  logic       burstRd = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] statusByte;
  logic [7:0] bvCount;
  logic [3:0] errCountA, errCountB;
  logic       irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rxAlarmStatus uut (
    .clk(clk), .rstN(rstN), .alarmLevel(alarmLevel), .bvEvent(bvEvent),
    .errEvent(errEvent), .statusRd(statusRd), .burstRd(burstRd), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .statusByte(statusByte), .bvCount(bvCount),
    .errCountA(errCountA), .errCountB(errCountB), .irq(irq)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, string what, int actual, int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  task automatic hostWrite(logic [1:0] a, logic [7:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    step();
    wrEn = 0;
  endtask

  task automatic readStatus(bit burst);
    statusRd = 1; burstRd = burst;
    step();
    statusRd = 0; burstRd = 0;
  endtask

  task automatic testReset();
    check("R10", "status", statusByte, 0);
    check("R10", "bvCount", bvCount, 0);
    check("R10", "errA", errCountA, 0);
    check("R10", "irq", irq, 0);
  endtask

  task automatic testRiseAndMask();
    alarmLevel[5] = 1;            // yellow
    step();
    check("R1", "yellow at bit5", statusByte, 8'h20);
    check("R9", "irq masked", irq, 0);
    hostWrite(2'd0, 8'hFF);       // R11 mask address
    check("R9", "irq enabled", irq, 1);
    hostWrite(2'd0, 8'hDF);
    check("R9", "irq bit masked", irq, 0);
    hostWrite(2'd0, 8'hFF);
    step();
    check("R2", "held level no change", statusByte, 8'h20);
  endtask

  task automatic testReadClear();
    readStatus(0);
    check("R3", "live flag kept", statusByte, 8'h20);
    check("R3", "irq kept", irq, 1);
    alarmLevel[5] = 0;
    step();
    check("R2", "falling keeps latch", statusByte, 8'h20);
    readStatus(1);
    check("R4", "burst read no clear", statusByte, 8'h20);
    readStatus(0);
    check("R3", "cleared after end", statusByte, 8'h00);
    check("R9", "irq dropped", irq, 0);
  endtask

  task automatic testMultiFlag();
    alarmLevel = 6'b010001;
    step();
    check("R1", "carrier and sync", statusByte, 8'h11);
    alarmLevel = 6'b010000;
    readStatus(0);
    check("R3", "partial clear", statusByte, 8'h10);
    alarmLevel = 6'b000000;
    readStatus(0);
    check("R3", "full clear", statusByte, 8'h00);
  endtask

  task automatic testViolation();
    bvEvent = 1;
    repeat (254) step();
    bvEvent = 0;
    check("R5", "count 254", bvCount, 254);
    check("R5", "bit7 not yet", statusByte, 0);
    bvEvent = 1; step(); bvEvent = 0;
    check("R5", "count 255", bvCount, 255);
    check("R5", "bit7 set", statusByte, 8'h80);
    check("R9", "irq from sat", irq, 1);
    bvEvent = 1; step(); step(); bvEvent = 0;
    check("R5", "no wrap", bvCount, 255);
    readStatus(0);
    check("R7", "read keeps bit7", statusByte, 8'h80);
    readStatus(1);
    check("R7", "burst keeps bit7", statusByte, 8'h80);
    hostWrite(2'd1, 8'hFF);
    check("R7", "all-ones preset keeps", statusByte, 8'h80);
    bvEvent = 1;
    hostWrite(2'd1, 8'h10);
    bvEvent = 0;
    check("R8", "preset wins", bvCount, 8'h10);
    check("R7", "bit7 cleared", statusByte, 0);
    check("R9", "irq cleared", irq, 0);
  endtask

  task automatic testErrors();
    errEvent = 2'b01;
    repeat (17) step();
    errEvent = 2'b00;
    check("R6", "errA sat", errCountA, 15);
    check("R6", "bit6 from A", statusByte, 8'h40);
    errEvent = 2'b10;
    repeat (15) step();
    errEvent = 2'b00;
    check("R6", "errB sat", errCountB, 15);
    hostWrite(2'd2, 8'h03);
    check("R11", "errA preset", errCountA, 3);
    check("R7", "bit6 held by B", statusByte, 8'h40);
    hostWrite(2'd3, 8'h00);
    check("R7", "bit6 cleared", statusByte, 0);
    check("R11", "errB preset", errCountB, 0);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1;
    step();
    testReset();
    testRiseAndMask();
    testReadClear();
    testMultiFlag();
    testViolation();
    testErrors();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule